// File: doc/BRIEF.md
# Display Register Access Bridge

This bridge sits between the host interfaces of a display controller and its control registers. It has two inputs. One is a 4 KB window of 16-bit memory-mapped reads and writes. The other is a port-style path where every access is 16 bits wide. The bridge turns both into accesses on two targets:

- a byte-wide legacy port space of 32 ports, driven on an external byte bus;
- an internal file of 16-bit extended display registers.

Some extended-register accesses are single-cycle. A memory-mapped word that lands in the legacy window needs a two-cycle sequence, and the request side stalls for one cycle while it runs. On a write, the low byte goes to the even (index) port first. The high byte then goes to the odd (data) port in the next cycle. One host write can therefore update an indexed legacy register.

The extended registers can be reached in two ways. The first is flat, with one halfword per register in the memory map. The second is through an index register and a data register on the port path. The data register answers at two aliased port numbers. The index is changed only by port-path writes to the index port.

Top module: `mmio_port_bridge`

## Requirements
- R1: Window offsets 0x000–0x3FF are reserved. A read there returns 0. A write there produces no legacy byte write and changes no extended register.
- R2: Offset 0x400+k (k = 0..31) selects legacy port k, where port k stands for the port at 0x3C0+k. Address bit 0 is ignored, so the byte pair always starts at the even port.
- R3: A word write in the legacy window is issued as two ordered byte writes. The low byte goes to the even port in the acceptance cycle. The high byte goes to the next odd port in the following cycle.
- R4: `m_ready` is low in the cycle after a legacy-window access is accepted. It is high at every other time.
- R5: A word read in the legacy window reads the even port first and then the odd port. It returns {odd byte, even byte}, with `m_rvalid` high two cycles after acceptance.
- R6: Offsets 0x500–0x515 access extended register (offset−0x500)>>1 directly. Reads return with `m_rvalid` one cycle after acceptance.
- R7: A port write to 0x01CE latches a 16-bit index, and a port read there returns it. The index resets to 0.
- R8: Port addresses 0x01CF and 0x01D0 both read and write the extended register selected by the latched index.
- R9: If the index is 11 or more, data-port reads return 0 and data-port writes are discarded.
- R10: Offsets 0x420–0x4FF and 0x516–0xFFF reach no target. Reads there return 0, and writes produce no byte write and no register change.
- R11: Accesses on the memory-mapped path never change the latched index.
- R12: A flat write and a port data write may hit the same register in one cycle. In that case the port-path value is kept. Writes to different registers in the same cycle both take effect.
- R13: Port addresses other than 0x01CE, 0x01CF and 0x01D0 read as 0 and ignore writes. Every port read returns with `p_rvalid` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_valid | input | 1 | Memory-mapped request valid |
| m_write | input | 1 | 1 = write, 0 = read |
| m_addr | input | 12 | Byte offset in the 4 KB window |
| m_wdata | input | 16 | Write data |
| m_ready | output | 1 | Request accepted when high together with m_valid |
| m_rvalid | output | 1 | Read data valid |
| m_rdata | output | 16 | Read data |
| p_valid | input | 1 | Port-style access valid (always accepted) |
| p_write | input | 1 | 1 = write, 0 = read |
| p_addr | input | 16 | Port number |
| p_wdata | input | 16 | Port write data |
| p_rvalid | output | 1 | Port read data valid |
| p_rdata | output | 16 | Port read data |
| vp_en | output | 1 | Legacy byte access strobe |
| vp_we | output | 1 | Legacy byte write enable |
| vp_addr | output | 5 | Legacy port number 0..31 |
| vp_wdata | output | 8 | Legacy byte write data |
| vp_rdata | input | 8 | Legacy byte read data, combinational from the port space |

## Verification
Both host paths can write the extended register file in the same clock. The bench holds a flat write and a port data write on the same edge, both aimed at one register, and then reads that register back through the flat path to confirm that the port value was kept. It repeats the test with two different registers and expects both values to land. In both cases it also checks that the latched index did not move.

// File: rtl/mmio_port_bridge.sv
module mmio_port_bridge #(
  parameter int          NREG        = 11,
  parameter logic [15:0] IDX_PORT    = 16'h01CE,
  parameter logic [15:0] DATA_PORT_A = 16'h01CF,
  parameter logic [15:0] DATA_PORT_B = 16'h01D0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        m_valid,
  input  logic        m_write,
  input  logic [11:0] m_addr,
  input  logic [15:0] m_wdata,
  output logic        m_ready,
  output logic        m_rvalid,
  output logic [15:0] m_rdata,
  input  logic        p_valid,
  input  logic        p_write,
  input  logic [15:0] p_addr,
  input  logic [15:0] p_wdata,
  output logic        p_rvalid,
  output logic [15:0] p_rdata,
  output logic        vp_en,
  output logic        vp_we,
  output logic [4:0]  vp_addr,
  output logic [7:0]  vp_wdata,
  input  logic [7:0]  vp_rdata
);
  localparam int          IW      = $clog2(NREG);
  localparam logic [11:0] FLAT_LO = 12'h500;
  localparam logic [11:0] FLAT_HI = FLAT_LO + 12'(2 * NREG - 1);

  logic [15:0] ext [NREG];
  logic [15:0] idx;
  logic        ph2, h_we;
  logic [3:0]  h_pair;
  logic [7:0]  h_hi, lo_byte;

  wire acc      = m_valid && m_ready;
  wire in_leg   = m_addr[11:5] == 7'h20;
  wire in_flat  = (m_addr >= FLAT_LO) && (m_addr <= FLAT_HI);
  wire [IW-1:0] fsel = m_addr[IW:1];
  wire idx_ok   = idx < 16'(NREG);
  wire [IW-1:0] isel = idx[IW-1:0];
  wire p_is_idx = p_addr == IDX_PORT;
  wire p_is_dat = (p_addr == DATA_PORT_A) || (p_addr == DATA_PORT_B);
  wire flat_wr  = acc && m_write && in_flat;
  wire port_wr  = p_valid && p_write && p_is_dat && idx_ok;
  wire idx_wr   = p_valid && p_write && p_is_idx;

  assign m_ready  = !ph2;
  assign vp_en    = ph2 || (acc && in_leg);
  assign vp_we    = ph2 ? h_we : m_write;
  assign vp_addr  = ph2 ? {h_pair, 1'b1} : {m_addr[4:1], 1'b0};
  assign vp_wdata = ph2 ? h_hi : m_wdata[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph2      <= 1'b0;
      h_we     <= 1'b0;
      h_pair   <= '0;
      h_hi     <= '0;
      lo_byte  <= '0;
      m_rvalid <= 1'b0;
      m_rdata  <= '0;
    end else begin
      m_rvalid <= 1'b0;
      if (ph2) begin
        ph2 <= 1'b0;
        if (!h_we) begin
          m_rvalid <= 1'b1;
          m_rdata  <= {vp_rdata, lo_byte};
        end
      end else if (acc) begin
        if (in_leg) begin
          ph2     <= 1'b1;
          h_we    <= m_write;
          h_pair  <= m_addr[4:1];
          h_hi    <= m_wdata[15:8];
          lo_byte <= vp_rdata;
        end else if (!m_write) begin
          m_rvalid <= 1'b1;
          m_rdata  <= in_flat ? ext[fsel] : 16'h0000;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) ext[i] <= '0;
      idx <= '0;
    end else begin
      if (flat_wr) ext[fsel] <= m_wdata;
      if (port_wr) ext[isel] <= p_wdata;
      if (idx_wr)  idx <= p_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_rvalid <= 1'b0;
      p_rdata  <= '0;
    end else begin
      p_rvalid <= p_valid && !p_write;
      if (p_valid && !p_write)
        p_rdata <= p_is_idx ? idx : (p_is_dat && idx_ok) ? ext[isel] : 16'h0000;
    end
  end

  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !m_write && (m_addr < 12'h400) |=> m_rvalid && (m_rdata == 16'h0000));

  p_hi_byte_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_leg && m_write |=> vp_en && vp_we
      && (vp_addr == {$past(m_addr[4:1]), 1'b1}) && (vp_wdata == $past(m_wdata[15:8])));

  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_leg |=> !m_ready);

  p_leg_read_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_leg && !m_write |=> !m_rvalid ##1 m_rvalid);

  p_oor_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid && !p_write && p_is_dat && !idx_ok |=> p_rvalid && (p_rdata == 16'h0000));

  p_idx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(idx));

  p_port_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flat_wr && port_wr && (fsel == isel) |=> ext[$past(isel)] == $past(p_wdata));
endmodule

// File: tb/sim_mmio_port_bridge.sv
module sim_mmio_port_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_valid = 0, m_write = 0, p_valid = 0, p_write = 0;
  logic [11:0] m_addr = 0;
  logic [15:0] m_wdata = 0, p_addr = 0, p_wdata = 0;
  logic m_ready, m_rvalid, p_rvalid, vp_en, vp_we;
  logic [15:0] m_rdata, p_rdata;
  logic [4:0] vp_addr;
  logic [7:0] vp_wdata, vp_rdata;

  always #2.5 clk = ~clk;

  mmio_port_bridge u0 (.*);

  logic [7:0]  lp [32];
  logic [4:0]  wl_a [64];
  logic [7:0]  wl_d [64];
  int          wl_c [64];
  int nw = 0, cyc = 0;
  assign vp_rdata = lp[vp_addr];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int k = 0; k < 32; k++) lp[k] <= 8'(8'hA0 + k);
    end else if (vp_en && vp_we) begin
      lp[vp_addr] <= vp_wdata;
      wl_a[nw[5:0]] <= vp_addr;
      wl_d[nw[5:0]] <= vp_wdata;
      wl_c[nw[5:0]] <= cyc;
      nw <= nw + 1;
    end
  end

  int checks = 0, errs = 0;
  bit done = 0, rdy_after = 0;
  logic [15:0] em [11];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mw(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!m_ready) @(negedge clk);
    m_valid = 1; m_write = 1; m_addr = a; m_wdata = d;
    @(posedge clk); #1;
    rdy_after = m_ready;
    m_valid = 0; m_write = 0;
    @(negedge clk);
  endtask

  task automatic mr(input logic [11:0] a, output logic [15:0] d, output int lat);
    @(negedge clk);
    while (!m_ready) @(negedge clk);
    m_valid = 1; m_write = 0; m_addr = a;
    @(posedge clk); #1;
    m_valid = 0;
    lat = 0; d = 16'hxxxx;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      lat++;
      if (m_rvalid) begin d = m_rdata; break; end
    end
  endtask

  task automatic pw(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    p_valid = 1; p_write = 1; p_addr = a; p_wdata = d;
    @(posedge clk); #1;
    p_valid = 0; p_write = 0;
  endtask

  task automatic pr(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    p_valid = 1; p_write = 0; p_addr = a;
    @(posedge clk); #1;
    p_valid = 0;
    @(negedge clk);
    chk(p_rvalid, "R13 p_rvalid", {31'd0, p_rvalid}, 1);
    d = p_rdata;
  endtask

  task automatic regs_match(input string tag);
    logic [15:0] d; int lat;
    for (int k = 0; k < 11; k++) begin
      mr(12'(12'h500 + 2 * k), d, lat);
      chk(d === em[k], tag, d, em[k]);
    end
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk(m_ready === 1'b1, "R4 ready after reset", {31'd0, m_ready}, 1);
    chk(m_rvalid === 1'b0 && p_rvalid === 1'b0, "R13 no rvalid at reset", {30'd0, m_rvalid, p_rvalid}, 0);
    pr(16'h01CE, d);
    chk(d === 16'h0000, "R7 index resets to 0", d, 0);
  endtask

  task automatic t_leg_write;
    int n0 = nw;
    mw(12'h406, 16'hBEEF);
    chk(rdy_after === 1'b0, "R4 stall after legacy write", {31'd0, rdy_after}, 0);
    repeat (2) @(negedge clk);
    chk(nw == n0 + 2, "R3 two byte writes", nw - n0, 2);
    chk(wl_a[n0[5:0]] == 5'd6 && wl_d[n0[5:0]] == 8'hEF, "R3 low byte to even port first",
        {wl_a[n0[5:0]], wl_d[n0[5:0]]}, {5'd6, 8'hEF});
    chk(wl_a[n0[5:0]+1] == 5'd7 && wl_d[n0[5:0]+1] == 8'hBE, "R3 high byte to odd port second",
        {wl_a[n0[5:0]+1], wl_d[n0[5:0]+1]}, {5'd7, 8'hBE});
    chk(wl_c[n0[5:0]+1] == wl_c[n0[5:0]] + 1, "R3 consecutive cycles",
        wl_c[n0[5:0]+1] - wl_c[n0[5:0]], 1);
    mw(12'h41B, 16'h1234);
    repeat (2) @(negedge clk);
    chk(lp[26] == 8'h34 && lp[27] == 8'h12, "R2 odd address uses even pair", {lp[26], lp[27]}, 16'h3412);
    mw(12'h41E, 16'h5678);
    repeat (2) @(negedge clk);
    chk(lp[30] == 8'h78 && lp[31] == 8'h56, "R2 last port pair", {lp[30], lp[31]}, 16'h7856);
  endtask

  task automatic t_leg_read;
    logic [15:0] d; int lat;
    mr(12'h408, d, lat);
    chk(d === 16'hA9A8, "R5 read even low odd high", d, 16'hA9A8);
    chk(lat == 2, "R5 legacy read latency", lat, 2);
    mr(12'h406, d, lat);
    chk(d === 16'hBEEF, "R5 read back written pair", d, 16'hBEEF);
  endtask

  task automatic t_flat;
    logic [15:0] d; int lat;
    for (int k = 0; k < 11; k++) begin
      mw(12'(12'h500 + 2 * k), 16'(16'h1100 + k));
      em[k] = 16'(16'h1100 + k);
    end
    regs_match("R6 flat read back");
    mr(12'h514, d, lat);
    chk(lat == 1, "R6 flat read latency", lat, 1);
    mw(12'h50D, 16'h6666);
    em[6] = 16'h6666;
    mr(12'h50C, d, lat);
    chk(d === 16'h6666, "R6 offset bit0 ignored", d, 16'h6666);
  endtask

  task automatic t_ports;
    logic [15:0] d; int lat;
    pw(16'h01CE, 16'd5);
    pr(16'h01CF, d);
    chk(d === em[5], "R8 data port A reads indexed reg", d, em[5]);
    pw(16'h01CE, 16'd3);
    pr(16'h01CE, d);
    chk(d === 16'd3, "R7 index read back", d, 3);
    pw(16'h01CF, 16'hCAFE); em[3] = 16'hCAFE;
    mr(12'h506, d, lat);
    chk(d === 16'hCAFE, "R8 port A write lands", d, 16'hCAFE);
    pw(16'h01D0, 16'hD00D); em[3] = 16'hD00D;
    pr(16'h01CF, d);
    chk(d === 16'hD00D, "R8 port B write, port A read", d, 16'hD00D);
    pr(16'h01D0, d);
    chk(d === 16'hD00D, "R8 port B read", d, 16'hD00D);
  endtask

  task automatic t_oor;
    logic [15:0] d;
    pw(16'h01CE, 16'd11);
    pr(16'h01CF, d);
    chk(d === 16'h0000, "R9 index 11 reads zero", d, 0);
    pw(16'h01D0, 16'h5555);
    pw(16'h01CE, 16'hFFFF);
    pw(16'h01CF, 16'h5A5A);
    pr(16'h01D0, d);
    chk(d === 16'h0000, "R9 index FFFF reads zero", d, 0);
    regs_match("R9 out-of-range writes discarded");
  endtask

  task automatic t_unmapped;
    logic [15:0] d; int lat;
    int n0 = nw;
    mw(12'h3FE, 16'hFFFF);
    mw(12'h000, 16'hFFFF);
    mr(12'h200, d, lat);
    chk(d === 16'h0000 && lat == 1, "R1 reserved read zero", {d, 16'(lat)}, {16'h0, 16'd1});
    mw(12'h420, 16'hEEEE);
    mw(12'h4FE, 16'hEEEE);
    mw(12'h516, 16'hEEEE);
    mw(12'hFFE, 16'hEEEE);
    for (int k = 0; k < 4; k++) begin
      mr(12'(k == 0 ? 12'h420 : k == 1 ? 12'h4FE : k == 2 ? 12'h516 : 12'hFFE), d, lat);
      chk(d === 16'h0000, "R10 unmapped read zero", d, 0);
    end
    chk(nw == n0, "R1 R10 no byte writes", nw - n0, 0);
    regs_match("R10 registers untouched");
  endtask

  task automatic t_idx_hold;
    logic [15:0] d;
    pw(16'h01CE, 16'd2);
    mw(12'h504, 16'h2222); em[2] = 16'h2222;
    mw(12'h400, 16'h0101);
    pr(16'h01CE, d);
    chk(d === 16'd2, "R11 index unchanged by mmio", d, 2);
  endtask

  task automatic t_collide;
    logic [15:0] d; int lat;
    pw(16'h01CE, 16'd4);
    @(negedge clk);
    m_valid = 1; m_write = 1; m_addr = 12'h508; m_wdata = 16'hAAAA;
    p_valid = 1; p_write = 1; p_addr = 16'h01D0; p_wdata = 16'hBBBB;
    @(posedge clk); #1;
    m_valid = 0; m_write = 0; p_valid = 0; p_write = 0;
    em[4] = 16'hBBBB;
    mr(12'h508, d, lat);
    chk(d === 16'hBBBB, "R12 port write wins same reg", d, 16'hBBBB);
    @(negedge clk);
    m_valid = 1; m_write = 1; m_addr = 12'h50A; m_wdata = 16'h1212;
    p_valid = 1; p_write = 1; p_addr = 16'h01CF; p_wdata = 16'h3434;
    @(posedge clk); #1;
    m_valid = 0; m_write = 0; p_valid = 0; p_write = 0;
    em[5] = 16'h1212; em[4] = 16'h3434;
    regs_match("R12 different regs both land");
    pr(16'h01CE, d);
    chk(d === 16'd4, "R12 R11 index kept", d, 4);
  endtask

  task automatic t_other_ports;
    logic [15:0] d;
    pw(16'h01CD, 16'h7777);
    pw(16'h03C4, 16'h7777);
    pr(16'h01CD, d);
    chk(d === 16'h0000, "R13 other port reads zero", d, 0);
    pr(16'h01CE, d);
    chk(d === 16'd4, "R13 index unaffected", d, 4);
    regs_match("R13 registers unaffected");
  endtask

  initial begin
    for (int k = 0; k < 11; k++) em[k] = 16'h0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset;
    regs_match("R6 registers reset to zero");
    t_leg_write;
    t_leg_read;
    t_flat;
    t_ports;
    t_oor;
    t_unmapped;
    t_idx_hold;
    t_collide;
    t_other_ports;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule